// File: doc/BRIEF.md
# Frame-Sync Serial Converter Port

This block is the digital serial port of a multichannel sampling converter, acting as a slave to a signal processor in a frame-synchronised mode. The host lowers chip select while the receive frame sync is low, which arms the port, and a strap input picks the transfer width at that moment. Each conversion then starts with a pulse on the receive frame sync. Once that pulse falls, the port counts serial-clock edges. It takes an 8-bit command on falling edges, picks an input channel, and sends acquire and sample strobes to the analog core at fixed edge counts. It then marks the result with a one-period transmit frame sync and shifts the conversion word out most significant bit first.

All port inputs are synchronised into the system clock domain and their edges are detected there, so the serial clock must be slow compared with the system clock. A new receive frame sync aborts the frame in progress and starts a new one. Raising chip select aborts the frame and shuts the port down until it is armed again. The conversion word itself comes from a behavioural data input.

Top module: `fsync_conv_port`

## Requirements
- R1: During and right after reset, `fs_out`, `sdo`, `acq_start`, `sample_strobe` and `core_awake` are 0 and `chan_sel` is 0.
- R2: A falling edge on `cs_n` arms the port only if `fs_in` is low at that moment. If `fs_in` is high, later frame syncs and serial clocks produce no strobe, no `fs_out` and no data.
- R3: Counting SCLK falling edges from 1 after `fs_in` falls, falls 1 to 8 carry the command MSB first. On fall 3, `chan_sel` takes {bit of fall 2, bit of fall 3} and a one-cycle `acq_start` pulse is issued.
- R4: One one-cycle `sample_strobe` pulse follows SCLK rising edge 7 of the frame (rising edges counted from 1 after `fs_in` falls) in narrow mode, and rising edge 15 in wide mode.
- R5: `fs_out` goes high at rising edge 8 (narrow) or 16 (wide) and drops at the next rising edge, so it is exactly one SCLK period wide.
- R6: From the rising edge after the `fs_out` edge, `sdo` presents the 14-bit `conv_word` (captured at the `fs_out` edge) MSB first, one bit per rising edge, then two zero bits. After that, and at every other time, it holds 0.
- R7: `width_sel` sampled at the arming `cs_n` fall selects narrow mode (0) or wide mode (1). Wide mode moves the sample, transmit-sync and data positions 8 rising edges later.
- R8: A rising edge on `fs_in` while armed aborts the frame at once: `fs_out` and `sdo` go to 0, and no further strobe of the old frame appears. The following `fs_in` fall restarts the edge count at 1. `chan_sel` keeps its last value.
- R9: A rising edge on `cs_n` aborts any frame and shuts the port down: `core_awake`, `fs_out` and `sdo` go to 0, and frame syncs are ignored until the port is armed again.
- R10: `core_awake` rises on a `fs_in` rising edge while armed and stays high until shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| width_sel | input | 1 | Transfer width strap: 0 narrow, 1 wide |
| fs_in | input | 1 | Receive frame sync from host |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial command data in |
| conv_word | input | RES_W (14) | Conversion result from the core |
| fs_out | output | 1 | Transmit frame sync |
| sdo | output | 1 | Serial result data out |
| core_awake | output | 1 | Wake request to the analog circuitry |
| chan_sel | output | CHAN_W (2) | Selected input channel |
| acq_start | output | 1 | One-cycle acquisition start strobe |
| sample_strobe | output | 1 | One-cycle sampling strobe |

## Verification
The hardest cases are aborts that land in the middle of a frame. One is a new frame sync that arrives while the result is half shifted out. Another, in wide mode, arrives between acquisition start and the sample point, so the pending sample strobe must never appear. A third is a chip-select rise that falls among the command bits. The bench builds each of these by giving a frame fewer serial clocks than it needs and then starting the next frame or shutdown at once. A behavioural edge-count model predicts every strobe, sync and data bit after each serial-clock edge, including the zeros after an aborted shift.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  // Falling edge that completes the command field.
  localparam int unsigned CMD_BITS  = 8;
  // Falling edge on which the channel is decoded and acquisition begins.
  localparam int unsigned ACQ_FALL  = 3;
  // Rising edge of the transmit sync in narrow mode; sampling is one edge earlier.
  localparam int unsigned TXFS_RISE = 8;

  typedef enum logic {
    XFER_NARROW = 1'b0,
    XFER_WIDE   = 1'b1
  } xfer_e;
endpackage

// File: rtl/fsync_sync.sv
module fsync_sync #(
  parameter int unsigned N      = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q, pipe_d;
    logic              prev_q, prev_d;

    always_comb begin
      pipe_d = {pipe_q[STAGES-2:0], async_i[b]};
      prev_d = pipe_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= {STAGES{INIT[b]}};
        prev_q <= INIT[b];
      end else begin
        pipe_q <= pipe_d;
        prev_q <= prev_d;
      end
    end

    assign lvl_o[b]  = pipe_q[STAGES-1];
    assign rise_o[b] = pipe_q[STAGES-1] & ~prev_q;
    assign fall_o[b] = ~pipe_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/fsync_seq.sv
module fsync_seq
  import fsync_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_rise_i,
  input  logic             cs_fall_i,
  input  logic             fs_lvl_i,
  input  logic             fs_rise_i,
  input  logic             fs_fall_i,
  input  logic             sck_rise_i,
  input  logic             sck_fall_i,
  input  logic             width_i,
  output xfer_e            xfer_o,
  output logic             awake_o,
  output logic             in_frame_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             clr_o,
  output logic             rise_ev_o,
  output logic             fall_ev_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             en_q, en_d;
  logic             awake_q, awake_d;
  logic             frame_q, frame_d;
  xfer_e            xfer_q, xfer_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign clr_o     = cs_rise_i | (en_q & (fs_rise_i | fs_fall_i));
  assign rise_ev_o = frame_q & sck_rise_i;
  assign fall_ev_o = frame_q & sck_fall_i;

  always_comb begin
    en_d    = en_q;
    xfer_d  = xfer_q;
    awake_d = awake_q;
    frame_d = frame_q;
    cnt_d   = cnt_q;

    if (cs_rise_i) begin
      en_d = 1'b0;
    end else if (cs_fall_i) begin
      en_d = ~fs_lvl_i;
      if (!fs_lvl_i) xfer_d = xfer_e'(width_i);
    end

    if (cs_rise_i)                awake_d = 1'b0;
    else if (en_q && fs_rise_i)   awake_d = 1'b1;

    if (cs_rise_i || !en_q)       frame_d = 1'b0;
    else if (fs_rise_i)           frame_d = 1'b0;
    else if (fs_fall_i)           frame_d = 1'b1;

    if (en_q && fs_fall_i)                    cnt_d = '0;
    else if (rise_ev_o && cnt_q != CNT_MAX)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      xfer_q  <= XFER_NARROW;
      awake_q <= 1'b0;
      frame_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      en_q    <= en_d;
      xfer_q  <= xfer_d;
      awake_q <= awake_d;
      frame_q <= frame_d;
      cnt_q   <= cnt_d;
    end
  end

  assign xfer_o     = xfer_q;
  assign awake_o    = awake_q;
  assign in_frame_o = frame_q;
  assign cnt_o      = cnt_q;

  // R9: a disarmed port is neither awake nor inside a frame.
  assert_shutdown_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!awake_q && !frame_q));
  // R8: a frame sync rising while armed ends the frame on the next cycle.
  assert_abort_ends_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && fs_rise_i) |=> !frame_q);
  // R10: leaving the awake state requires a chip-select rise.
  assert_awake_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (awake_q && !cs_rise_i) |=> awake_q);
endmodule

// File: rtl/fsync_cmd.sv
module fsync_cmd
  import fsync_pkg::*;
#(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned CHAN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              fall_ev_i,
  input  logic              in_frame_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              sdi_i,
  output logic [CHAN_W-1:0] chan_o,
  output logic              acq_o
);
  localparam logic [CNT_W-1:0] FIRST = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] ACQ   = CNT_W'(ACQ_FALL);

  logic [CMD_BITS-1:0] cmd_q, cmd_d, cmd_shift;
  logic [CHAN_W-1:0]   chan_q, chan_d;
  logic                acq_q, acq_d;
  logic                cmd_unused;

  assign cmd_shift  = {cmd_q[CMD_BITS-2:0], sdi_i};
  assign cmd_unused = cmd_q[CMD_BITS-1];

  always_comb begin
    cmd_d  = cmd_q;
    chan_d = chan_q;
    acq_d  = 1'b0;
    if (clr_i) begin
      cmd_d = '0;
    end else if (fall_ev_i && cnt_i >= FIRST && cnt_i <= LAST) begin
      cmd_d = cmd_shift;
      if (cnt_i == ACQ) begin
        chan_d = cmd_shift[CHAN_W-1:0];
        acq_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      chan_q <= '0;
      acq_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      chan_q <= chan_d;
      acq_q  <= acq_d;
    end
  end

  assign chan_o = chan_q;
  assign acq_o  = acq_q;

  // R3: the acquisition strobe is a single-cycle pulse.
  assert_acq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acq_q |=> !acq_q);
  // R3: acquisition only starts inside an active frame.
  assert_acq_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acq_q |-> in_frame_i);
  // R3: the channel only moves together with an acquisition strobe.
  assert_chan_with_acq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_q |=> (acq_q || $stable(chan_q)));
endmodule

// File: rtl/fsync_tx.sv
module fsync_tx
  import fsync_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned RES_W = 14,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned EXT   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             rise_ev_i,
  input  logic             in_frame_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  xfer_e            xfer_i,
  input  logic [RES_W-1:0] word_i,
  output logic             fs_out_o,
  output logic             sdo_o,
  output logic             sample_o
);
  localparam int unsigned     PAD    = OUT_W - RES_W;
  localparam logic [CNT_W:0]  TPOS_N = (CNT_W+1)'(TXFS_RISE);
  localparam logic [CNT_W:0]  TPOS_W = (CNT_W+1)'(TXFS_RISE + EXT);

  logic [OUT_W-1:0] sh_q, sh_d;
  logic             sdo_q, sdo_d;
  logic             fso_q, fso_d;
  logic             smp_q, smp_d;
  logic [CNT_W:0]   k, tpos;

  assign k    = {1'b0, cnt_i} + 1'b1;
  assign tpos = (xfer_i == XFER_WIDE) ? TPOS_W : TPOS_N;

  always_comb begin
    sh_d  = sh_q;
    sdo_d = sdo_q;
    fso_d = fso_q;
    smp_d = 1'b0;
    if (clr_i) begin
      sh_d  = '0;
      sdo_d = 1'b0;
      fso_d = 1'b0;
    end else if (rise_ev_i) begin
      fso_d = (k == tpos);
      smp_d = (k == tpos - 1'b1);
      if (k == tpos) begin
        sh_d  = OUT_W'(word_i) << PAD;
        sdo_d = 1'b0;
      end else if (k > tpos) begin
        sdo_d = sh_q[OUT_W-1];
        sh_d  = sh_q << 1;
      end else begin
        sdo_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
      fso_q <= 1'b0;
      smp_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      sdo_q <= sdo_d;
      fso_q <= fso_d;
      smp_q <= smp_d;
    end
  end

  assign fs_out_o = fso_q;
  assign sdo_o    = sdo_q;
  assign sample_o = smp_q;

  // R4: the sampling strobe is a single-cycle pulse.
  assert_sample_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_q |=> !smp_q);
  // R5: the transmit sync only appears inside a frame.
  assert_fsout_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fso_q |-> in_frame_i);
  // R6: no result bit is driven while the transmit sync is high.
  assert_sdo_idle_at_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fso_q |-> !sdo_q);
  // R6: outside a frame the data line stays low.
  assert_sdo_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame_i |-> !sdo_q);
endmodule

// File: rtl/fsync_conv_port.sv
module fsync_conv_port
  import fsync_pkg::*;
#(
  parameter int unsigned CHAN_W      = 2,
  parameter int unsigned RES_W       = 14,
  parameter int unsigned OUT_W       = 16,
  parameter int unsigned EXT         = 8,
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              width_sel,
  input  logic              fs_in,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [RES_W-1:0]  conv_word,
  output logic              fs_out,
  output logic              sdo,
  output logic              core_awake,
  output logic [CHAN_W-1:0] chan_sel,
  output logic              acq_start,
  output logic              sample_strobe
);
  localparam int unsigned NSYNC = 5;
  localparam int unsigned I_CS  = 0;
  localparam int unsigned I_FS  = 1;
  localparam int unsigned I_SCK = 2;
  localparam int unsigned I_SDI = 3;
  localparam int unsigned I_WID = 4;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_l = rst_pipe_q[1];

  logic [NSYNC-1:0] lvl, rise, fall;
  logic             sync_unused;

  fsync_sync #(
    .N      (NSYNC),
    .STAGES (SYNC_STAGES),
    .INIT   (NSYNC'(1) << I_CS)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_l),
    .async_i ({width_sel, sdi, sclk, fs_in, cs_n}),
    .lvl_o   (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign sync_unused = ^{lvl[I_CS], lvl[I_SCK], rise[I_SDI], fall[I_SDI],
                         rise[I_WID], fall[I_WID]};

  xfer_e            xfer;
  logic             in_frame, clr, rise_ev, fall_ev;
  logic [CNT_W-1:0] cnt;

  fsync_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_l),
    .cs_rise_i  (rise[I_CS]),
    .cs_fall_i  (fall[I_CS]),
    .fs_lvl_i   (lvl[I_FS]),
    .fs_rise_i  (rise[I_FS]),
    .fs_fall_i  (fall[I_FS]),
    .sck_rise_i (rise[I_SCK]),
    .sck_fall_i (fall[I_SCK]),
    .width_i    (lvl[I_WID]),
    .xfer_o     (xfer),
    .awake_o    (core_awake),
    .in_frame_o (in_frame),
    .cnt_o      (cnt),
    .clr_o      (clr),
    .rise_ev_o  (rise_ev),
    .fall_ev_o  (fall_ev)
  );

  fsync_cmd #(.CNT_W(CNT_W), .CHAN_W(CHAN_W)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_l),
    .clr_i      (clr),
    .fall_ev_i  (fall_ev),
    .in_frame_i (in_frame),
    .cnt_i      (cnt),
    .sdi_i      (lvl[I_SDI]),
    .chan_o     (chan_sel),
    .acq_o      (acq_start)
  );

  fsync_tx #(.CNT_W(CNT_W), .RES_W(RES_W), .OUT_W(OUT_W), .EXT(EXT)) u_tx (
    .clk        (clk),
    .rst_n      (rst_l),
    .clr_i      (clr),
    .rise_ev_i  (rise_ev),
    .in_frame_i (in_frame),
    .cnt_i      (cnt),
    .xfer_i     (xfer),
    .word_i     (conv_word),
    .fs_out_o   (fs_out),
    .sdo_o      (sdo),
    .sample_o   (sample_strobe)
  );

  // R4: acquisition start and sampling never coincide.
  assert_strobes_apart_R4: assert property (@(posedge clk) disable iff (!rst_l)
    !(acq_start && sample_strobe));
endmodule

// File: tb/fsync_conv_port_bench.sv
module fsync_conv_port_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cs_n, width_sel, fs_in, sclk, sdi;
  logic [13:0] conv_word;
  logic        fs_out, sdo, core_awake, acq_start, sample_strobe;
  logic [1:0]  chan_sel;

  fsync_conv_port u_fsync_conv_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .width_sel(width_sel), .fs_in(fs_in),
    .sclk(sclk), .sdi(sdi), .conv_word(conv_word), .fs_out(fs_out), .sdo(sdo),
    .core_awake(core_awake), .chan_sel(chan_sel), .acq_start(acq_start),
    .sample_strobe(sample_strobe)
  );

  int vectors = 0, miscompares = 0;
  int acq_seen = 0, samp_seen = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (acq_start === 1'b1)     acq_seen++;
    if (sample_strobe === 1'b1) samp_seen++;
  end

  // Behavioural model state
  bit          m_en = 0, m_wide = 0, m_frame = 0, m_awake = 0;
  int          m_k = 0, exp_acq = 0, exp_samp = 0;
  logic [7:0]  m_cmd = '0;
  logic [1:0]  m_chan = '0;
  logic [13:0] m_word = '0;
  logic        exp_fs = 0, exp_sdo = 0;

  function automatic int tpos();
    return m_wide ? 16 : 8;
  endfunction

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic bad(string req, string ctx, string sig, int got, int exp);
    miscompares++;
    $display("FAIL %s [%s] %s got %0d expected %0d", req, ctx, sig, got, exp);
  endtask

  task automatic check(string ctx);
    vectors++;
    if (fs_out !== exp_fs)      bad("R5", ctx, "fs_out", int'(fs_out), int'(exp_fs));
    if (sdo !== exp_sdo)        bad("R6", ctx, "sdo", int'(sdo), int'(exp_sdo));
    if (core_awake !== m_awake) bad("R10", ctx, "core_awake", int'(core_awake), int'(m_awake));
    if (chan_sel !== m_chan)    bad("R3", ctx, "chan_sel", int'(chan_sel), int'(m_chan));
    if (acq_seen != exp_acq)    bad("R3", ctx, "acq_start pulses", acq_seen, exp_acq);
    if (samp_seen != exp_samp)  bad("R4", ctx, "sample_strobe pulses", samp_seen, exp_samp);
  endtask

  task automatic sck_rise(logic b, string ctx);
    sdi  = b;
    sclk = 1'b1;
    if (m_frame) begin
      m_k++;
      if (m_k == tpos() - 1) exp_samp++;
      exp_fs  = (m_k == tpos());
      exp_sdo = (m_k > tpos() && m_k <= tpos() + 14) ? m_word[13 - (m_k - tpos() - 1)] : 1'b0;
    end else begin
      exp_fs  = 1'b0;
      exp_sdo = 1'b0;
    end
    settle();
    check(ctx);
  endtask

  task automatic sck_fall(string ctx);
    sclk = 1'b0;
    if (m_frame && m_k >= 1 && m_k <= 8) begin
      m_cmd = {m_cmd[6:0], sdi};
      if (m_k == 3) begin
        m_chan = m_cmd[1:0];
        exp_acq++;
      end
    end
    settle();
    check(ctx);
  endtask

  task automatic fs_pulse(string ctx);
    fs_in = 1'b1;
    if (m_en) begin
      m_frame = 0; m_awake = 1; exp_fs = 0; exp_sdo = 0;
    end
    settle();
    check(ctx);
    fs_in = 1'b0;
    if (m_en) begin
      m_frame = 1; m_k = 0; m_cmd = '0;
    end
    settle();
    check(ctx);
  endtask

  task automatic run_frame(logic [7:0] cmd, logic [13:0] word, int ncyc, string ctx);
    conv_word = word;
    m_word    = word;
    fs_pulse(ctx);
    for (int i = 1; i <= ncyc; i++) begin
      sck_rise((i <= 8) ? cmd[8 - i] : 1'b1, ctx);
      sck_fall(ctx);
    end
  endtask

  task automatic cs_down(logic fsv, logic w, string ctx);
    fs_in = fsv;
    width_sel = w;
    settle();
    cs_n = 1'b0;
    m_en = !fsv;
    if (!fsv) m_wide = w;
    settle();
    if (fsv) begin
      fs_in = 1'b0;
      settle();
    end
    check(ctx);
  endtask

  task automatic cs_up(string ctx);
    cs_n = 1'b1;
    m_en = 0; m_frame = 0; m_awake = 0; exp_fs = 0; exp_sdo = 0;
    settle();
    check(ctx);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; width_sel = 1'b0; fs_in = 1'b0;
    sclk = 1'b0; sdi = 1'b0; conv_word = '0;
    repeat (5) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    settle();
    check("R1 after reset");

    // Narrow mode: full frame plus extra clocks showing trailing zeros (R6)
    cs_down(1'b0, 1'b0, "R2 arm narrow");
    run_frame(8'b0100_0000, 14'h2A5C, 28, "R6 narrow frame");
    run_frame(8'b1011_0110, 14'h3FFF, 24, "R3 all-ones word");
    // Abort in the middle of the result shift, then restart (R8)
    run_frame(8'b0110_0000, 14'h1234, 12, "R8 abort mid shift");
    run_frame(8'b0010_0000, 14'h0001, 25, "R8 restart");
    // Shutdown among command bits, then frames ignored (R9)
    run_frame(8'b0000_0000, 14'h2000, 5, "R9 before shutdown");
    cs_up("R9 shutdown");
    run_frame(8'b0110_0000, 14'h0155, 20, "R9 ignored frame");
    // Chip select falls while frame sync high: port stays disarmed (R2)
    cs_down(1'b1, 1'b0, "R2 fs high at cs fall");
    run_frame(8'b0100_0000, 14'h0AAA, 20, "R2 not armed");
    cs_up("R2 release");
    // Wide mode (R7), abort before the sample point (R8)
    cs_down(1'b0, 1'b1, "R7 arm wide");
    run_frame(8'b0110_0000, 14'h2D3B, 36, "R7 wide frame");
    run_frame(8'b0010_0000, 14'h3FFF, 12, "R8 wide abort before sample");
    run_frame(8'b0100_0000, 14'h1555, 33, "R7 wide restart");
    cs_up("R9 final shutdown");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule